// File: doc/BRIEF.md
# Burst Header Receiver and Timestamper

This block sits at the front of the control path of a burst-switching core node. It takes burst header frames that arrive as a stream of 16-bit words on a valid/ready input. Each frame is two words long. The block checks the frame's sync byte and its parity, then pulls out the fields that the scheduler needs: egress port, burst length, offset, priority class and ingress channel. It stamps the request with absolute start and end slots taken from a wrapping control-slot counter. The reformatted request is then offered on one of `NUM_DEST` per-egress valid/ready outputs. These outputs share one payload bus.

A frame that fails any check never produces a request. Instead it bumps a saturating error counter. When the selected egress is not ready, the request is held in place and `in_ready` stays low, so no request is lost.

The control state machine has four states:
- `ST_HUNT`: waiting for a first word.
- `ST_TAIL`: waiting for the second word.
- `ST_JUDGE`: checking parity and destination.
- `ST_OFFER`: presenting the request.

It moves between them on these transitions:
- T_SYNC_OK: HUNT to TAIL, when a first word with the correct sync byte is accepted.
- T_SYNC_BAD: HUNT to HUNT, when a first word has a wrong sync byte. The word is dropped and counted.
- T_TAIL_TAKEN: TAIL to JUDGE, when the second word is accepted and the slot count is latched.
- T_ACCEPT: JUDGE to OFFER, when parity and destination are both good.
- T_REJECT: JUDGE to HUNT, when either check fails. The frame is counted as an error.
- T_CONSUMED: OFFER to HUNT, when the selected egress asserts ready.

Top module: `burst_hdr_rx`

## Requirements
- R1: A first word is accepted as a frame start only when bits [15:8] equal `SYNC_PATTERN` (default 0xA5). Any other first word is dropped, adds one to the error count, and the next word is again treated as a candidate first word.
- R2: The 32 bits of the two words must XOR to 0 (even parity; bit 0 of the second word is the parity bit). A frame that fails this produces no request and adds one to the error count.
- R3: The fields are taken from fixed bit positions:
  - destination from first word [7:5];
  - offset from first word [4:0];
  - length from second word [15:10];
  - priority from second word [9:8];
  - channel from second word [7:5].
  
  Length, priority and channel appear unchanged on `req_len`, `req_prio` and `req_chan`. Second-word bits [4:1] only take part in the parity check.
- R4: The slot counter starts at 0 after reset. It advances by one on each cycle with `slot_tick` high, and goes from `SLOT_PERIOD-1` to 0. The stamp of a frame is the counter value in the cycle its second word is accepted; a tick in that same cycle is not yet included.
- R5: `req_start` equals (stamp + offset) mod `SLOT_PERIOD`.
- R6: `req_end` equals (`req_start` + length) mod `SLOT_PERIOD`, so the length always equals end minus start modulo the period.
- R7: A request is signalled by exactly one bit of `req_valid`, the bit whose index equals the destination field.
- R8: A destination value of `NUM_DEST` or more makes the frame invalid. Such a frame produces no request and adds one to the error count.
- R9: Timing and back-pressure:
  - `req_valid` rises two clock edges after the edge that accepts the second word.
  - While a request waits for ready, `in_ready` is low, no input word is taken, and the payload stays stable.
  - Ready on a non-selected output does not consume the request.
- R10: After reset, `in_ready` is high, `req_valid` is all zeros and `err_count` is 0. The error count saturates at its maximum value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slot_tick | input | 1 | One-cycle pulse marking a control-slot boundary |
| in_data | input | 16 | Header word |
| in_valid | input | 1 | Header word present |
| in_ready | output | 1 | Block can take a header word |
| req_valid | output | NUM_DEST | Per-egress request valid |
| req_ready | input | NUM_DEST | Per-egress request ready |
| req_start | output | clog2(SLOT_PERIOD) | Scheduled start slot |
| req_end | output | clog2(SLOT_PERIOD) | Scheduled end slot |
| req_len | output | 6 | Burst length in slots |
| req_prio | output | 2 | Priority class |
| req_chan | output | 3 | Ingress channel |
| err_count | output | ERR_W | Saturating count of rejected frames and words |

## Verification
The bench builds the block with `NUM_DEST` = 3, `SLOT_PERIOD` = 100 and `ERR_W` = 3.

- Three egresses leave destination values 3 to 7 free to test as out-of-range.
- A period of 100 is not a power of two, so the start and end sums really go through the subtract-on-overflow path. The period still exceeds the largest length plus the largest offset (63 + 31).
- A 3-bit error counter reaches saturation after a handful of bad frames.

The stamp vectors are chosen so that the counter wraps, and so that both the start and end sums cross the period.

// File: rtl/bhr_pkg.sv
package bhr_pkg;

    localparam int WORD_W  = 16;
    localparam int SYNC_W  = 8;
    localparam int DEST_FW = 3;
    localparam int OFS_FW  = 5;
    localparam int LEN_FW  = 6;
    localparam int PRIO_FW = 2;
    localparam int CHAN_FW = 3;

    typedef enum logic [1:0] {
        ST_HUNT  = 2'd0,
        ST_TAIL  = 2'd1,
        ST_JUDGE = 2'd2,
        ST_OFFER = 2'd3
    } rx_state_e;

    typedef struct packed {
        logic [DEST_FW-1:0] dest;
        logic [OFS_FW-1:0]  ofs;
        logic [LEN_FW-1:0]  len;
        logic [PRIO_FW-1:0] prio;
        logic [CHAN_FW-1:0] chan;
    } hdr_fields_t;

    function automatic hdr_fields_t split_header(input logic [WORD_W-1:0] first_w,
                                                 input logic [WORD_W-1:0] second_w);
        hdr_fields_t f;
        f.dest = first_w[7:5];
        f.ofs  = first_w[4:0];
        f.len  = second_w[15:10];
        f.prio = second_w[9:8];
        f.chan = second_w[7:5];
        return f;
    endfunction

endpackage

// File: rtl/bhr_slot_counter.sv
module bhr_slot_counter #(
    parameter int SLOT_PERIOD = 128,
    localparam int TS_W = $clog2(SLOT_PERIOD)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tick,
    output logic [TS_W-1:0] count
);

    localparam logic [TS_W-1:0] LAST = TS_W'(SLOT_PERIOD - 1);

    logic [TS_W-1:0] count_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (tick) begin
            count_q <= (count_q == LAST) ? '0 : count_q + 1'b1;
        end
    end

    assign count = count_q;

    AST_CNT_IDLE: assert property (@(posedge clk) disable iff (!rst_n) !tick |=> $stable(count_q)); // R4
    AST_CNT_WRAP: assert property (@(posedge clk) disable iff (!rst_n) (tick && count_q == LAST) |=> count_q == '0); // R4

endmodule

// File: rtl/bhr_slot_add.sv
module bhr_slot_add #(
    parameter int SLOT_PERIOD = 128,
    parameter int B_W = 6,
    localparam int TS_W = $clog2(SLOT_PERIOD)
) (
    input  logic [TS_W-1:0] a,
    input  logic [B_W-1:0]  b,
    output logic [TS_W-1:0] sum
);

    localparam logic [TS_W:0] PER = (TS_W+1)'(SLOT_PERIOD);

    logic [TS_W:0] raw;

    always_comb begin
        raw = {1'b0, a} + {{(TS_W+1-B_W){1'b0}}, b};
        if (raw >= PER) begin
            sum = TS_W'(raw - PER);
        end else begin
            sum = TS_W'(raw);
        end
    end

endmodule

// File: rtl/bhr_frame_fsm.sv
module bhr_frame_fsm
    import bhr_pkg::*;
#(
    parameter int NUM_DEST = 4,
    parameter int TS_W = 7,
    parameter logic [SYNC_W-1:0] SYNC_PATTERN = 8'hA5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] in_data,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [TS_W-1:0]   slot_count,
    output logic [TS_W-1:0]   stamp,
    input  logic [TS_W-1:0]   start_calc,
    input  logic [TS_W-1:0]   end_calc,
    output logic [TS_W-1:0]   start_q,
    output logic [TS_W-1:0]   end_q,
    output hdr_fields_t       fields,
    output logic              offer,
    input  logic              sel_ready,
    output logic              err_pulse
);

    localparam logic [DEST_FW:0] DEST_LIM = (DEST_FW+1)'(NUM_DEST);

    rx_state_e         state_q, state_d;
    logic [WORD_W-1:0] w0_q, w1_q;
    logic [TS_W-1:0]   stamp_q;
    logic [TS_W-1:0]   start_r, end_r;
    logic              sync_ok;
    logic              parity_ok;
    logic              dest_ok;
    logic              frame_ok;

    assign fields    = split_header(w0_q, w1_q);
    assign sync_ok   = (in_data[WORD_W-1 -: SYNC_W] == SYNC_PATTERN);
    assign parity_ok = ~(^{w0_q, w1_q});
    assign dest_ok   = ({1'b0, fields.dest} < DEST_LIM);
    assign frame_ok  = parity_ok && dest_ok;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_HUNT;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HUNT: begin
                if (in_valid && sync_ok) begin
                    state_d = ST_TAIL;
                end
            end
            ST_TAIL: begin
                if (in_valid) begin
                    state_d = ST_JUDGE;
                end
            end
            ST_JUDGE: begin
                state_d = frame_ok ? ST_OFFER : ST_HUNT;
            end
            ST_OFFER: begin
                if (sel_ready) begin
                    state_d = ST_HUNT;
                end
            end
        endcase
    end

    // outputs
    always_comb begin
        in_ready  = 1'b0;
        offer     = 1'b0;
        err_pulse = 1'b0;
        unique case (state_q)
            ST_HUNT: begin
                in_ready  = 1'b1;
                err_pulse = in_valid && !sync_ok;
            end
            ST_TAIL: begin
                in_ready = 1'b1;
            end
            ST_JUDGE: begin
                err_pulse = !frame_ok;
            end
            ST_OFFER: begin
                offer = 1'b1;
            end
        endcase
    end

    // datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            w0_q    <= '0;
            w1_q    <= '0;
            stamp_q <= '0;
            start_r <= '0;
            end_r   <= '0;
        end else begin
            if (state_q == ST_HUNT && in_valid && sync_ok) begin
                w0_q <= in_data;
            end
            if (state_q == ST_TAIL && in_valid) begin
                w1_q    <= in_data;
                stamp_q <= slot_count;
            end
            if (state_q == ST_JUDGE && frame_ok) begin
                start_r <= start_calc;
                end_r   <= end_calc;
            end
        end
    end

    assign stamp   = stamp_q;
    assign start_q = start_r;
    assign end_q   = end_r;

    AST_OFFER_HOLDS: assert property (@(posedge clk) disable iff (!rst_n) (state_q == ST_OFFER && !sel_ready) |=> (state_q == ST_OFFER && $stable(start_r) && $stable(end_r) && $stable(fields))); // R9
    AST_NO_TAKE_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n) (state_q == ST_JUDGE || state_q == ST_OFFER) |=> ($stable(w0_q) && $stable(w1_q))); // R9
    AST_PARITY_REJECT: assert property (@(posedge clk) disable iff (!rst_n) (state_q == ST_JUDGE && !parity_ok) |=> state_q == ST_HUNT); // R2
    AST_DEST_REJECT: assert property (@(posedge clk) disable iff (!rst_n) (state_q == ST_JUDGE && {1'b0, fields.dest} >= DEST_LIM) |=> state_q != ST_OFFER); // R8
    AST_SYNC_GATE: assert property (@(posedge clk) disable iff (!rst_n) $rose(state_q == ST_TAIL) |-> $past(in_data[WORD_W-1 -: SYNC_W] == SYNC_PATTERN)); // R1

endmodule

// File: rtl/bhr_steer.sv
module bhr_steer
    import bhr_pkg::*;
#(
    parameter int NUM_DEST = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                offer,
    input  logic [DEST_FW-1:0]  dest,
    input  logic [NUM_DEST-1:0] req_ready,
    output logic [NUM_DEST-1:0] req_valid,
    output logic                sel_ready
);

    localparam logic [DEST_FW:0] DEST_LIM = (DEST_FW+1)'(NUM_DEST);

    for (genvar g = 0; g < NUM_DEST; g++) begin : g_port
        assign req_valid[g] = offer && (dest == DEST_FW'(g));
    end

    assign sel_ready = |(req_valid & req_ready);

    AST_ONE_DEST: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(req_valid)); // R7
    AST_DEST_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n) (|req_valid) |-> ({1'b0, dest} < DEST_LIM)); // R8

endmodule

// File: rtl/bhr_err_counter.sv
module bhr_err_counter #(
    parameter int ERR_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    output logic [ERR_W-1:0] count
);

    logic [ERR_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (inc && cnt_q != '1) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign count = cnt_q;

    AST_ERR_NO_DECREASE: assert property (@(posedge clk) disable iff (!rst_n) 1'b1 |=> cnt_q >= $past(cnt_q)); // R10
    AST_ERR_QUIET: assert property (@(posedge clk) disable iff (!rst_n) !inc |=> $stable(cnt_q)); // R10

endmodule

// File: rtl/burst_hdr_rx.sv
module burst_hdr_rx
    import bhr_pkg::*;
#(
    parameter int NUM_DEST = 4,
    parameter int SLOT_PERIOD = 128,
    parameter int ERR_W = 8,
    parameter logic [7:0] SYNC_PATTERN = 8'hA5,
    localparam int TS_W = $clog2(SLOT_PERIOD)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                slot_tick,
    input  logic [15:0]         in_data,
    input  logic                in_valid,
    output logic                in_ready,
    output logic [NUM_DEST-1:0] req_valid,
    input  logic [NUM_DEST-1:0] req_ready,
    output logic [TS_W-1:0]     req_start,
    output logic [TS_W-1:0]     req_end,
    output logic [5:0]          req_len,
    output logic [1:0]          req_prio,
    output logic [2:0]          req_chan,
    output logic [ERR_W-1:0]    err_count
);

    logic [TS_W-1:0] slot_count;
    logic [TS_W-1:0] stamp;
    logic [TS_W-1:0] start_calc;
    logic [TS_W-1:0] end_calc;
    hdr_fields_t     fields;
    logic            offer;
    logic            sel_ready;
    logic            err_pulse;

    bhr_slot_counter #(.SLOT_PERIOD(SLOT_PERIOD)) u_slot_counter (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (slot_tick),
        .count (slot_count)
    );

    bhr_slot_add #(.SLOT_PERIOD(SLOT_PERIOD), .B_W(OFS_FW)) u_add_start (
        .a   (stamp),
        .b   (fields.ofs),
        .sum (start_calc)
    );

    bhr_slot_add #(.SLOT_PERIOD(SLOT_PERIOD), .B_W(LEN_FW)) u_add_end (
        .a   (start_calc),
        .b   (fields.len),
        .sum (end_calc)
    );

    bhr_frame_fsm #(
        .NUM_DEST     (NUM_DEST),
        .TS_W         (TS_W),
        .SYNC_PATTERN (SYNC_PATTERN)
    ) u_frame_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_data    (in_data),
        .in_valid   (in_valid),
        .in_ready   (in_ready),
        .slot_count (slot_count),
        .stamp      (stamp),
        .start_calc (start_calc),
        .end_calc   (end_calc),
        .start_q    (req_start),
        .end_q      (req_end),
        .fields     (fields),
        .offer      (offer),
        .sel_ready  (sel_ready),
        .err_pulse  (err_pulse)
    );

    bhr_steer #(.NUM_DEST(NUM_DEST)) u_steer (
        .clk       (clk),
        .rst_n     (rst_n),
        .offer     (offer),
        .dest      (fields.dest),
        .req_ready (req_ready),
        .req_valid (req_valid),
        .sel_ready (sel_ready)
    );

    bhr_err_counter #(.ERR_W(ERR_W)) u_err_counter (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (err_pulse),
        .count (err_count)
    );

    assign req_len  = fields.len;
    assign req_prio = fields.prio;
    assign req_chan = fields.chan;

    AST_START_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n) (|req_valid) |-> (int'(req_start) < SLOT_PERIOD)); // R5
    AST_SPAN_IS_LEN: assert property (@(posedge clk) disable iff (!rst_n) (|req_valid) |-> (((int'(req_end) + SLOT_PERIOD - int'(req_start)) % SLOT_PERIOD) == int'(req_len))); // R6

endmodule

// File: tb/test_burst_hdr_rx.sv
module test_burst_hdr_rx;

    localparam int ND  = 3;
    localparam int PER = 100;
    localparam int EW  = 3;
    localparam int TW  = $clog2(PER);

    typedef struct packed {
        logic [7:0] ticks;
        logic [2:0] dest;
        logic [4:0] ofs;
        logic [5:0] len;
        logic [1:0] prio;
        logic [2:0] chan;
        logic [6:0] exp_s;
        logic [6:0] exp_e;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{8'd0,  3'd0, 5'd0,  6'd1,  2'd0, 3'd0, 7'd0,  7'd1},
        '{8'd5,  3'd1, 5'd31, 6'd63, 2'd3, 3'd7, 7'd36, 7'd99},
        '{8'd10, 3'd2, 5'd7,  6'd20, 2'd1, 3'd2, 7'd22, 7'd42},
        '{8'd40, 3'd0, 5'd30, 6'd63, 2'd2, 3'd5, 7'd85, 7'd48},
        '{8'd44, 3'd1, 5'd0,  6'd0,  2'd0, 3'd1, 7'd99, 7'd99},
        '{8'd1,  3'd2, 5'd1,  6'd2,  2'd3, 3'd3, 7'd1,  7'd3},
        '{8'd90, 3'd1, 5'd20, 6'd10, 2'd1, 3'd6, 7'd10, 7'd20},
        '{8'd9,  3'd0, 5'd31, 6'd63, 2'd0, 3'd4, 7'd30, 7'd93}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          slot_tick = 1'b0;
    logic [15:0]   in_data = '0;
    logic          in_valid = 1'b0;
    logic          in_ready;
    logic [ND-1:0] req_valid;
    logic [ND-1:0] req_ready = '0;
    logic [TW-1:0] req_start;
    logic [TW-1:0] req_end;
    logic [5:0]    req_len;
    logic [1:0]    req_prio;
    logic [2:0]    req_chan;
    logic [EW-1:0] err_count;

    int checks = 0;
    int fails = 0;
    int cnt_m = 0;

    always #4 clk = ~clk;

    burst_hdr_rx #(.NUM_DEST(ND), .SLOT_PERIOD(PER), .ERR_W(EW)) i_burst_hdr_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .slot_tick (slot_tick),
        .in_data   (in_data),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .req_valid (req_valid),
        .req_ready (req_ready),
        .req_start (req_start),
        .req_end   (req_end),
        .req_len   (req_len),
        .req_prio  (req_prio),
        .req_chan  (req_chan),
        .err_count (err_count)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] first_word(input logic [2:0] d, input logic [4:0] o);
        return {8'hA5, d, o};
    endfunction

    function automatic logic [15:0] second_word(input logic [15:0] w0, input logic [5:0] l,
                                                input logic [1:0] p, input logic [2:0] c);
        logic [15:0] body;
        body = {l, p, c, 5'b0};
        body[0] = ^{w0, body};
        return body;
    endfunction

    task automatic send_word(input logic [15:0] w, input logic tk);
        logic ok;
        @(negedge clk);
        in_data = w;
        in_valid = 1'b1;
        slot_tick = tk;
        forever begin
            ok = in_ready;
            @(posedge clk);
            if (ok) break;
            @(negedge clk);
        end
    endtask

    task automatic send_frame(input logic [15:0] w0, input logic [15:0] w1, input logic tk);
        send_word(w0, 1'b0);
        send_word(w1, tk);
        @(negedge clk);
        in_valid = 1'b0;
        slot_tick = 1'b0;
    endtask

    task automatic do_ticks(input int n);
        for (int t = 0; t < n; t++) begin
            @(negedge clk);
            slot_tick = 1'b1;
            @(negedge clk);
            slot_tick = 1'b0;
            cnt_m = (cnt_m + 1) % PER;
        end
    endtask

    task automatic take_req(input string tag, input int d, input int s, input int e,
                            input int l, input int p, input int c);
        for (int k = 0; k < 10; k++) begin
            if (|req_valid) break;
            @(negedge clk);
        end
        chk({tag, " R7 valid bit"}, int'(req_valid), 1 << d);
        chk({tag, " R5 start"}, int'(req_start), s);
        chk({tag, " R6 end"}, int'(req_end), e);
        chk({tag, " R3 len"}, int'(req_len), l);
        chk({tag, " R3 prio"}, int'(req_prio), p);
        chk({tag, " R3 chan"}, int'(req_chan), c);
        req_ready = ND'(1 << d);
        @(negedge clk);
        req_ready = '0;
        chk({tag, " R9 consumed"}, int'(req_valid), 0);
        chk({tag, " R9 ready again"}, int'(in_ready), 1);
    endtask

    task automatic expect_reject(input string tag, input int err_exp);
        repeat (4) @(negedge clk);
        chk({tag, " no request"}, int'(req_valid), 0);
        chk({tag, " error count"}, int'(err_count), err_exp);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        logic [15:0] w0, w1;
        int s, e;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R10 reset state
        chk("R10 reset in_ready", int'(in_ready), 1);
        chk("R10 reset req_valid", int'(req_valid), 0);
        chk("R10 reset err_count", int'(err_count), 0);

        // table of vectors: R3 R4 R5 R6 R7
        foreach (VECS[i]) begin
            do_ticks(int'(VECS[i].ticks));
            w0 = first_word(VECS[i].dest, VECS[i].ofs);
            w1 = second_word(w0, VECS[i].len, VECS[i].prio, VECS[i].chan);
            send_frame(w0, w1, 1'b0);
            take_req($sformatf("vec%0d", i), int'(VECS[i].dest), int'(VECS[i].exp_s),
                     int'(VECS[i].exp_e), int'(VECS[i].len), int'(VECS[i].prio), int'(VECS[i].chan));
        end
        chk("R4 table no errors", int'(err_count), 0);

        // R1 bad sync word dropped, then a good frame is found
        send_word(16'h5A21, 1'b0);
        @(negedge clk);
        in_valid = 1'b0;
        expect_reject("R1 bad sync", 1);
        w0 = first_word(3'd1, 5'd5);
        w1 = second_word(w0, 6'd10, 2'd2, 3'd3);
        send_frame(w0, w1, 1'b0);
        s = (cnt_m + 5) % PER;
        e = (s + 10) % PER;
        take_req("R1 resync", 1, s, e, 10, 2, 3);

        // R2 parity failure
        w0 = first_word(3'd0, 5'd3);
        w1 = second_word(w0, 6'd4, 2'd1, 3'd1) ^ 16'h0002;
        send_frame(w0, w1, 1'b0);
        expect_reject("R2 parity", 2);

        // R8 destination out of range
        w0 = first_word(3'd3, 5'd3);
        w1 = second_word(w0, 6'd4, 2'd1, 3'd1);
        send_frame(w0, w1, 1'b0);
        expect_reject("R8 dest 3", 3);
        w0 = first_word(3'd7, 5'd0);
        w1 = second_word(w0, 6'd8, 2'd0, 3'd0);
        send_frame(w0, w1, 1'b0);
        expect_reject("R8 dest 7", 4);

        // R9 latency and back-pressure
        w0 = first_word(3'd2, 5'd9);
        w1 = second_word(w0, 6'd33, 2'd3, 3'd6);
        send_frame(w0, w1, 1'b0);
        s = (cnt_m + 9) % PER;
        e = (s + 33) % PER;
        chk("R9 latency edge one", int'(req_valid), 0);
        @(negedge clk);
        chk("R9 latency edge two", int'(req_valid), 4);
        in_data = 16'h0000;
        in_valid = 1'b1;
        req_ready = 3'b011;
        repeat (5) begin
            @(negedge clk);
            chk("R9 held valid", int'(req_valid), 4);
            chk("R9 in_ready low", int'(in_ready), 0);
            chk("R9 start stable", int'(req_start), s);
        end
        in_valid = 1'b0;
        req_ready = '0;
        take_req("R9 released", 2, s, e, 33, 3, 6);
        chk("R9 stalled word not taken", int'(err_count), 4);

        // R4 tick in the same cycle as the second word
        w0 = first_word(3'd0, 5'd2);
        w1 = second_word(w0, 6'd5, 2'd0, 3'd2);
        send_frame(w0, w1, 1'b1);
        s = (cnt_m + 2) % PER;
        e = (s + 5) % PER;
        cnt_m = (cnt_m + 1) % PER;
        take_req("R4 tick with tail", 0, s, e, 5, 0, 2);
        w0 = first_word(3'd1, 5'd0);
        w1 = second_word(w0, 6'd0, 2'd1, 3'd0);
        send_frame(w0, w1, 1'b0);
        take_req("R4 tick counted", 1, cnt_m, cnt_m, 0, 1, 0);

        // R10 saturation of the error count
        for (int k = 0; k < 3; k++) begin
            send_word(16'h1234, 1'b0);
        end
        @(negedge clk);
        in_valid = 1'b0;
        expect_reject("R10 count up", 7);
        send_word(16'h0F0F, 1'b0);
        @(negedge clk);
        in_valid = 1'b0;
        expect_reject("R10 saturated", 7);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule